// File: doc/BRIEF.md
# Network Activity LED Combiner with Pulse Stretch

This block drives a bank of network activity LED pins. Every pin owns a small configuration register that picks which of eight status lines may light it: receive activity, transmit activity, collision, link up, full duplex, wake packet seen, 100 Mb/s speed and receive address match. The selected lines are merged into one event per pin. The event can light the LED directly, or it can pass through a pulse stretcher so that an event lasting a single clock still shows as a visible blink.

The stretcher is a three-stage shift register that shares one slow tick, about 38 Hz. A live event fills all three stages at once. While no event is present, each tick shifts in a zero. The LED stays lit while any stage holds a one, so a short event stays visible for two to three tick periods. The pin output is modelled as an open-drain pull-down enable. A per-pin polarity bit picks whether the pad is pulled low while the LED is lit or while it is dark.

Top module: `led_status_drive`

## Requirements
- R1: A pin's event is high exactly when some status line is high and that line's enable bit in the pin's register is set. Register bits 7:0 enable, from bit 0 upward: receive, transmit, collision, link, full duplex, wake packet, 100 Mb/s speed, address match. A high event lights the pin in the same cycle.
- R2: When register bit 8 (stretch on) is 0, the pin's lit state equals its event in every cycle, with no added delay.
- R3: When bit 8 is 1, the pin lights in the same cycle as the event. After the event drops, the pin stays lit up to and including the cycle of the third tick that follows. It goes dark in the next cycle.
- R4: If an event is present in a cycle that carries a tick, the stretcher refills and does not shift. A held event keeps the pin lit for its whole length and is followed by a full stretch.
- R5: The tick is a single-cycle pulse every TICK_DIV clocks, first seen TICK_DIV-1 cycles after reset is released. A one-cycle event therefore stretches to between 2*TICK_DIV+1 and 3*TICK_DIV lit cycles.
- R6: `led_pull_low` equals the lit state XOR register bit 9 (invert). With bit 9 at 0 the pad is pulled low while the LED is lit and released otherwise.
- R7: After reset every register has bit 8 = 1 and bit 9 = 0. The enables are: pin 0 link (bit 3), pin 1 receive (bit 0), pin 2 transmit (bit 1), pin 3 speed (bit 6), and any further pin receive. All stretchers are empty.
- R8: A cycle with `cfg_we[p]` high loads `cfg_data` into pin p's register at the next clock edge. The registers of the other pins stay as they were.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| status | input | 8 | Status lines, bit order as in R1 |
| cfg_we | input | NUM_PINS | Per-pin register write strobe |
| cfg_data | input | 10 | Register write value (enables, stretch on, invert) |
| led_lit | output | NUM_PINS | Logical LED on state per pin |
| led_pull_low | output | NUM_PINS | Open-drain pull-down enable per pin; 0 means released |

## Verification
The bench measures how long a one-cycle pulse stays lit against the 2*TICK_DIV+1 to 3*TICK_DIV window. A stretcher with the wrong depth, or one that drains without waiting for the tick, lands outside that window. It holds an event across several ticks: a design that lets a tick win over a live event goes dark too early or stretches too little afterwards. It rewrites one pin's register and checks that its neighbours keep their defaults and that bypass mode drops in the same cycle. It also flips the polarity bit, which a wrong XOR would show as an inverted pad, and it reapplies reset to confirm that the default sources return.

// File: rtl/led_pkg.sv
package led_pkg;

    localparam int unsigned NUM_SRC      = 8;
    localparam int unsigned STRETCH_BITS = 3;

    // status line positions
    localparam int unsigned SRC_RX   = 0;
    localparam int unsigned SRC_TX   = 1;
    localparam int unsigned SRC_COL  = 2;
    localparam int unsigned SRC_LINK = 3;
    localparam int unsigned SRC_FDX  = 4;
    localparam int unsigned SRC_WAKE = 5;
    localparam int unsigned SRC_FAST = 6;
    localparam int unsigned SRC_ADDR = 7;

    typedef struct packed {
        logic               invert;      // bit 9
        logic               stretch_on;  // bit 8
        logic [NUM_SRC-1:0] src_en;      // bits 7:0
    } pin_cfg_t;

    localparam int unsigned CFG_W = $bits(pin_cfg_t);

    function automatic pin_cfg_t reset_cfg(input int unsigned pin);
        pin_cfg_t c;
        c.invert     = 1'b0;
        c.stretch_on = 1'b1;
        c.src_en     = '0;
        case (pin)
            0:       c.src_en[SRC_LINK] = 1'b1;
            1:       c.src_en[SRC_RX]   = 1'b1;
            2:       c.src_en[SRC_TX]   = 1'b1;
            3:       c.src_en[SRC_FAST] = 1'b1;
            default: c.src_en[SRC_RX]   = 1'b1;
        endcase
        return c;
    endfunction

    function automatic logic any_hit(input logic [NUM_SRC-1:0] st,
                                     input logic [NUM_SRC-1:0] en);
        return |(st & en);
    endfunction

endpackage

// File: rtl/led_tick_div.sv
module led_tick_div #(
    parameter int unsigned DIV = 1315789
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int unsigned W = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [W-1:0] LAST = W'(DIV - 1);

    logic [W-1:0] cnt;

    assign tick = (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst)       cnt <= '0;
        else if (tick) cnt <= '0;
        else           cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/led_stretch.sv
module led_stretch #(
    parameter int unsigned DEPTH = led_pkg::STRETCH_BITS
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic set,
    output logic held
);
    logic [DEPTH-1:0] sr;

    generate
        if (DEPTH > 1) begin : g_multi
            always_ff @(posedge clk) begin
                if (rst)       sr <= '0;
                else if (set)  sr <= '1;
                else if (tick) sr <= {sr[DEPTH-2:0], 1'b0};
            end
        end else begin : g_single
            always_ff @(posedge clk) begin
                if (rst)       sr <= '0;
                else if (set)  sr <= '1;
                else if (tick) sr <= '0;
            end
        end
    endgenerate

    assign held = |sr;
endmodule

// File: rtl/led_pin_chan.sv
module led_pin_chan
    import led_pkg::*;
#(
    parameter int unsigned PIN = 0
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               tick,
    input  logic [NUM_SRC-1:0] status,
    input  logic               wr_en,
    input  pin_cfg_t           wr_cfg,
    output pin_cfg_t           cfg_q,
    output logic               lit,
    output logic               pull_low
);
    logic evt;
    logic held;

    always_ff @(posedge clk) begin
        if (rst)        cfg_q <= reset_cfg(PIN);
        else if (wr_en) cfg_q <= wr_cfg;
    end

    assign evt = any_hit(status, cfg_q.src_en);

    led_stretch #(.DEPTH(STRETCH_BITS)) u_stretch (
        .clk  (clk),
        .rst  (rst),
        .tick (tick),
        .set  (evt),
        .held (held)
    );

    assign lit      = cfg_q.stretch_on ? (evt | held) : evt;
    assign pull_low = lit ^ cfg_q.invert;
endmodule

// File: rtl/led_status_drive.sv
module led_status_drive
    import led_pkg::*;
#(
    parameter int unsigned NUM_PINS = 4,
    parameter int unsigned TICK_DIV = 1315789
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_SRC-1:0]  status,
    input  logic [NUM_PINS-1:0] cfg_we,
    input  logic [CFG_W-1:0]    cfg_data,
    output logic [NUM_PINS-1:0] led_lit,
    output logic [NUM_PINS-1:0] led_pull_low
);
    logic                      tick;
    pin_cfg_t                  wr_cfg;
    pin_cfg_t [NUM_PINS-1:0]   cfg_q;

    assign wr_cfg = pin_cfg_t'(cfg_data);

    led_tick_div #(.DIV(TICK_DIV)) u_div (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    generate
        for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
            led_pin_chan #(.PIN(p)) u_chan (
                .clk      (clk),
                .rst      (rst),
                .tick     (tick),
                .status   (status),
                .wr_en    (cfg_we[p]),
                .wr_cfg   (wr_cfg),
                .cfg_q    (cfg_q[p]),
                .lit      (led_lit[p]),
                .pull_low (led_pull_low[p])
            );
        end
    endgenerate
endmodule

// File: rtl/led_status_drive_chk.sv
module led_status_drive_chk
    import led_pkg::*;
#(
    parameter int unsigned NUM_PINS = 4
) (
    input logic                    clk,
    input logic                    rst,
    input logic [NUM_SRC-1:0]      status,
    input logic                    tick,
    input pin_cfg_t [NUM_PINS-1:0] cfg_q,
    input logic [NUM_PINS-1:0]     led_lit
);
    assert_tick_single_R5: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);

    generate
        for (genvar p = 0; p < NUM_PINS; p++) begin : g_chk
            assert_event_lights_R1: assert property (@(posedge clk) disable iff (rst)
                (|(status & cfg_q[p].src_en)) |-> led_lit[p]);

            assert_bypass_follow_R2: assert property (@(posedge clk) disable iff (rst)
                !cfg_q[p].stretch_on |-> (led_lit[p] == |(status & cfg_q[p].src_en)));

            assert_drop_on_tick_R3: assert property (@(posedge clk) disable iff (rst)
                (!$past(rst) && $past(cfg_q[p].stretch_on) && cfg_q[p].stretch_on
                 && $past(led_lit[p]) && !led_lit[p]) |-> $past(tick));

            assert_reset_default_R7: assert property (@(posedge clk) disable iff (rst)
                $past(rst) |-> (cfg_q[p] == reset_cfg(p)));
        end
    endgenerate
endmodule

bind led_status_drive led_status_drive_chk #(.NUM_PINS(NUM_PINS)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .status  (status),
    .tick    (tick),
    .cfg_q   (cfg_q),
    .led_lit (led_lit)
);

// File: tb/led_status_drive_bench.sv
`timescale 1ns/1ps
module led_status_drive_bench;
    localparam int NP  = 4;
    localparam int DIV = 6;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [7:0]    status = '0;
    logic [NP-1:0] cfg_we = '0;
    logic [9:0]    cfg_data = '0;
    logic [NP-1:0] led_lit;
    logic [NP-1:0] led_pull_low;

    int errors = 0;
    int checks = 0;

    always #10 clk = ~clk;

    led_status_drive #(.NUM_PINS(NP), .TICK_DIV(DIV)) u_led_status_drive (
        .clk          (clk),
        .rst          (rst),
        .status       (status),
        .cfg_we       (cfg_we),
        .cfg_data     (cfg_data),
        .led_lit      (led_lit),
        .led_pull_low (led_pull_low)
    );

    // ---------------- behavioural reference ----------------
    int         ref_phase;
    int         ref_left [NP];
    logic [9:0] ref_cfg  [NP];

    function automatic logic [9:0] dflt(input int p);
        case (p)
            0:       return 10'h108;
            1:       return 10'h101;
            2:       return 10'h102;
            3:       return 10'h140;
            default: return 10'h101;
        endcase
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            ref_phase = 0;
            for (int p = 0; p < NP; p++) begin
                ref_left[p] = 0;
                ref_cfg[p]  = dflt(p);
            end
        end else begin
            bit tk;
            tk = (ref_phase == DIV - 1);
            for (int p = 0; p < NP; p++) begin
                if ((status & ref_cfg[p][7:0]) != 0) ref_left[p] = 3;
                else if (tk && ref_left[p] > 0)      ref_left[p] = ref_left[p] - 1;
                if (cfg_we[p]) ref_cfg[p] = cfg_data;
            end
            ref_phase = tk ? 0 : ref_phase + 1;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic chk_rng(input string req, input int act, input int lo, input int hi);
        checks++;
        if (act < lo || act > hi) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d..%0d", req, act, lo, hi);
        end
    endtask

    // per-cycle comparison against the reference
    always @(negedge clk) begin
        if (!rst) begin
            for (int p = 0; p < NP; p++) begin
                bit ev, lit_e;
                ev    = (status & ref_cfg[p][7:0]) != 0;
                lit_e = ref_cfg[p][8] ? (ev || ref_left[p] > 0) : ev;
                chk(ref_cfg[p][8] ? "R3/R4/R5 lit" : "R2 lit", int'(led_lit[p]), int'(lit_e));
                chk("R6 pull", int'(led_pull_low[p]), int'(lit_e ^ ref_cfg[p][9]));
            end
        end
    end

    task automatic step();
        @(posedge clk); #2;
    endtask

    task automatic look();
        @(negedge clk);
    endtask

    task automatic drain();
        repeat (3 * DIV + 2) step();
    endtask

    // one-cycle pulse on src, returns lit cycles after the drop on pin p
    task automatic stretch_len(input int p, input int src, output int n);
        step(); status = 8'(1 << src);
        step(); status = '0;
        n = 0;
        forever begin
            look();
            if (!led_lit[p]) break;
            n++;
            step();
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int n, mn, mx;
        repeat (3) @(posedge clk);
        #2 rst = 1'b0;
        look();
        chk("R7 reset lit", int'(led_lit), 0);
        chk("R7 reset pull", int'(led_pull_low), 0);

        // default sources
        step(); status = 8'h08; look(); chk("R7 link->pin0", int'(led_lit), 1);
        step(); status = '0; drain();
        step(); status = 8'h01; look(); chk("R7 rx->pin1", int'(led_lit), 2);
        step(); status = '0; drain();
        step(); status = 8'h02; look(); chk("R7 tx->pin2", int'(led_lit), 4);
        step(); status = '0; drain();
        step(); status = 8'h40; look(); chk("R7 speed->pin3", int'(led_lit), 8);
        step(); status = '0; drain();
        step(); status = 8'h04; look(); chk("R1 unselected collision", int'(led_lit), 0);
        step(); status = '0;

        // stretch length of a one-cycle pulse
        stretch_len(1, 0, n);
        chk_rng("R3 stretch length", n, 2 * DIV + 1, 3 * DIV);

        // held event across ticks
        step(); status = 8'h01;
        for (int i = 0; i < 3 * DIV + 1; i++) begin
            look(); chk("R4 held lit", int'(led_lit[1]), 1);
            step();
        end
        status = '0;
        n = 0;
        forever begin
            look();
            if (!led_lit[1]) break;
            n++;
            step();
        end
        chk_rng("R4 stretch after hold", n, 2 * DIV + 1, 3 * DIV);

        // rewrite pin1: collision + full duplex, bypass
        step(); cfg_we = 4'b0010; cfg_data = 10'h014;
        step(); cfg_we = '0; status = 8'h08;
        look(); chk("R8 pin0 keeps link", int'(led_lit[0]), 1);
        chk("R8 pin1 ignores link", int'(led_lit[1]), 0);
        step(); status = 8'h04; look(); chk("R1 collision", int'(led_lit[1]), 1);
        step(); status = 8'h10; look(); chk("R1 full duplex", int'(led_lit[1]), 1);
        step(); status = '0;    look(); chk("R2 same-cycle drop", int'(led_lit[1]), 0);
        step(); status = 8'h01; look(); chk("R1 rx not selected", int'(led_lit[1]), 0);
        step(); status = '0;

        // invert polarity on pin2, address match source, bypass
        step(); cfg_we = 4'b0100; cfg_data = 10'h280;
        step(); cfg_we = '0;
        look(); chk("R6 inverted dark pull", int'(led_pull_low[2]), 1);
        step(); status = 8'h80;
        look(); chk("R6 inverted lit", int'(led_lit[2]), 1);
        chk("R6 inverted lit pull", int'(led_pull_low[2]), 0);
        step(); status = '0; drain();
        step(); status = 8'h08;
        look(); chk("R6 normal pull", int'(led_pull_low[0]), 1);
        step(); status = '0; drain();

        // tick period through several phases on pin3
        mn = 1000; mx = 0;
        for (int k = 0; k < DIV; k++) begin
            stretch_len(3, 6, n);
            if (n < mn) mn = n;
            if (n > mx) mx = n;
            repeat (k) step();
        end
        chk_rng("R5 min stretch", mn, 2 * DIV + 1, 3 * DIV);
        chk_rng("R5 max stretch", mx, 2 * DIV + 1, 3 * DIV);

        // reset restores defaults
        step(); rst = 1'b1;
        step(); step(); rst = 1'b0;
        step(); status = 8'h01; look(); chk("R7 rx->pin1 after reset", int'(led_lit), 2);
        step(); status = '0;
        drain();
        finish_run();
    end
endmodule